// File: doc/BRIEF.md
# Block-Paced Half-Duplex SPI Master

This block is an SPI master for a host that reaches it through a small word-wide register port. Each transfer moves data in one direction only: the host writes bytes out to a peripheral, or reads bytes back from it. The host picks a clock divider code, the serial mode, the direction and a byte count, and then issues a start command. Data passes through a 16-byte staging buffer, one block at a time. The serial side pauses after every block until the host acknowledges it.

On a write, the host fills the buffer with up to four 32-bit words and then strobes "block loaded". The master shifts that block out and raises a "send more" flag. On a read, the master fills the buffer and raises a "data waiting" flag. The host drains the words and then strobes "block taken". While one of these handshakes is open, the serial clock rests at its idle level and no bit moves, so a slow host never overruns or starves the wire.

The serial clock is a division of the block clock, chosen from an even-divider table by a 4-bit code. Both clock polarities and both phases are supported. A three-wire option reads the returning data from a separate shared-pin input and releases the output driver.

Top module: `spi_bm_top`

## Requirements
- R1: The serial clock period is 2*max(K,1) block-clock cycles, where K is the divider code in CTRL bits [11:8]. Each SCLK level therefore lasts max(K,1) cycles.
- R2: CTRL bit 16 selects the direction: 0 is write and 1 is read. During a read, mosi_o stays low.
- R3: WLEN (address 1) and RLEN (address 2) hold the byte count minus one in bits [15:0]. A transfer clocks exactly 8*(count) data bits.
- R4: Data moves in blocks of min(16, remaining) bytes. After each block the master stops, with exactly the bytes of all completed blocks clocked.
- R5: Byte k of a block sits in word k/4 at bits [8*(k%4)+7 : 8*(k%4)]. TXDATA (address 5) is written and RXDATA (address 6) is read in word order. Unused lanes of the last read word read as zero.
- R6: Write handshake. After start, no bit moves until the host writes CMD (address 3) with bit 1 set. When that block has been shifted out, STATUS (address 4) bit 1 rises. The same strobe clears it. While the master waits, SCLK holds its idle level.
- R7: Read handshake. STATUS bit 2 rises once a block has been received. No further bit moves, and SCLK stays idle, until CMD bit 2 is written. That strobe clears the flag and fetches the next block.
- R8: CMD bit 0 starts a transfer only when CTRL bit 0 (enable) is set and no transfer is running. In any other case it has no effect.
- R9: CTRL bit 1 sets the idle SCLK level. With CTRL bit 2 clear, data is sampled on the leading edge; with it set, data is sampled on the trailing edge. Each byte goes most significant bit first.
- R10: With CTRL bit 3 set and the read direction selected, mosi_oe is low and read data comes from dio_i. Otherwise mosi_oe follows the enable bit and read data comes from miso_i.
- R11: cs_n_o is the inverse of CTRL bit 4.
- R12: STATUS bit 0 (busy) is high from an accepted start until the last bit of the programmed length has completed.
- R13: After reset, STATUS reads 0, cs_n_o is 1, and sclk_o and mosi_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RXDATA) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from the address |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for the data-out pin |
| miso_i | input | 1 | Serial data in, four-wire mode |
| dio_i | input | 1 | Shared-pin data in, three-wire mode |
| cs_n_o | output | 1 | Chip select, active low |

## Verification
Writes and reads are swept over every length from 1 to 20 bytes. This range separates the single partial block, a full block landing exactly on 16, and a full block followed by a short tail, and it exposes any slip in lane placement or zero padding. The sweeps rotate through all four CPOL/CPHA combinations and three divider codes, so an edge mix-up fails as corrupted data rather than going unseen. One three-wire read drives opposite values on miso_i and dio_i, which shows which pin is being sampled. Every divider code has its SCLK period timed; starts are tried while disabled and while busy; and the edge count is checked during each open handshake to show the stall.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;

    localparam int BLK_BYTES_DEF = 16;
    localparam int DATA_W_DEF    = 32;
    localparam int LEN_W_DEF     = 16;
    localparam int DIV_W         = 4;
    localparam int ADDR_W        = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_WLEN = 3'd1;
    localparam logic [ADDR_W-1:0] A_RLEN = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMD  = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd4;
    localparam logic [ADDR_W-1:0] A_TXD  = 3'd5;
    localparam logic [ADDR_W-1:0] A_RXD  = 3'd6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_TX,
        ST_ARM,
        ST_SHIFT,
        ST_WAIT_RX
    } xfer_state_t;

    typedef struct packed {
        logic             dir_rd;
        logic [DIV_W-1:0] div;
        logic             cs_on;
        logic             three_w;
        logic             cpha;
        logic             cpol;
        logic             en;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [31:0] w);
        ctrl_t c;
        c.en      = w[0];
        c.cpol    = w[1];
        c.cpha    = w[2];
        c.three_w = w[3];
        c.cs_on   = w[4];
        c.div     = w[11:8];
        c.dir_rd  = w[16];
        return c;
    endfunction

    function automatic logic [31:0] pack_ctrl(input ctrl_t c);
        return {15'd0, c.dir_rd, 4'd0, c.div, 3'd0,
                c.cs_on, c.three_w, c.cpha, c.cpol, c.en};
    endfunction

    // Cycles per SCLK level: codes 0 and 1 both give the shortest period
    function automatic logic [DIV_W-1:0] half_cycles(input logic [DIV_W-1:0] code);
        return (code == '0) ? DIV_W'(1) : code;
    endfunction

endpackage

// File: rtl/spi_bm_clkgen.sv
module spi_bm_clkgen
    import spi_bm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_code,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] half;

    assign half = half_cycles(div_code);
    assign tick = run && (cnt == half - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == half - 1'b1) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        (tick && half > DIV_W'(1)) |=> !tick); // R1

endmodule

// File: rtl/spi_bm_shifter.sv
module spi_bm_shifter #(
    parameter int BLK_BYTES = 16,
    localparam int BIDX_W   = $clog2(BLK_BYTES),
    localparam int NB_W     = BIDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [NB_W-1:0]   nbytes,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              tick,
    input  logic              sin,
    input  logic [7:0]        tx_byte,
    output logic [BIDX_W-1:0] fetch_idx,
    output logic              active,
    output logic              sclk,
    output logic              sout,
    output logic              rx_we,
    output logic [BIDX_W-1:0] rx_idx,
    output logic [7:0]        rx_byte,
    output logic              done
);

    logic [BIDX_W-1:0] byte_idx;
    logic [2:0]        bit_idx;
    logic              half_q;
    logic [7:0]        shreg;
    logic [7:0]        rxreg;
    logic [NB_W-1:0]   nb_q;
    logic              byte_end;
    logic              last_byte;

    assign fetch_idx = active ? byte_idx + 1'b1 : '0;
    assign byte_end  = active && tick && half_q && (bit_idx == 3'd0);
    assign last_byte = ({1'b0, byte_idx} == nb_q - 1'b1);
    assign rx_we     = byte_end;
    assign rx_idx    = byte_idx;
    assign rx_byte   = rxreg;
    assign done      = byte_end && last_byte;
    assign sout      = shreg[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            byte_idx <= '0;
            bit_idx  <= 3'd7;
            half_q   <= 1'b0;
            shreg    <= '0;
            rxreg    <= '0;
            nb_q     <= '0;
            sclk     <= 1'b0;
        end else if (!active) begin
            sclk <= cpol;
            if (go) begin
                active   <= 1'b1;
                byte_idx <= '0;
                bit_idx  <= 3'd7;
                half_q   <= 1'b0;
                shreg    <= tx_byte;
                nb_q     <= nbytes;
                sclk     <= cpol ^ cpha;
            end
        end else if (tick) begin
            if (!half_q) begin
                // Sampling edge for both phase settings
                half_q <= 1'b1;
                rxreg  <= {rxreg[6:0], sin};
                sclk   <= ~sclk;
            end else begin
                half_q <= 1'b0;
                if (bit_idx == 3'd0) begin
                    if (last_byte) begin
                        active <= 1'b0;
                        shreg  <= '0;
                        sclk   <= cpol;
                    end else begin
                        byte_idx <= byte_idx + 1'b1;
                        bit_idx  <= 3'd7;
                        shreg    <= tx_byte;
                        sclk     <= ~sclk;
                    end
                end else begin
                    bit_idx <= bit_idx - 1'b1;
                    shreg   <= {shreg[6:0], 1'b0};
                    sclk    <= ~sclk;
                end
            end
        end
    end

    AST_BYTE_RANGE: assert property (@(posedge clk) disable iff (rst)
        active |-> ({1'b0, byte_idx} < nb_q)); // R4

    AST_SCLK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (active && !tick) |=> $stable(sclk)); // R9

endmodule

// File: rtl/spi_bm_blkbuf.sv
module spi_bm_blkbuf #(
    parameter int BLK_BYTES = 16,
    parameter int DATA_W    = 32,
    localparam int LANES    = DATA_W / 8,
    localparam int WORDS    = BLK_BYTES / LANES,
    localparam int LANE_W   = $clog2(LANES),
    localparam int WIDX_W   = $clog2(WORDS),
    localparam int BIDX_W   = $clog2(BLK_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              ptr_rst,
    input  logic              host_we,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [BIDX_W-1:0] sh_ridx,
    output logic [7:0]        sh_rbyte,
    input  logic              sh_we,
    input  logic [BIDX_W-1:0] sh_widx,
    input  logic [7:0]        sh_wbyte
);

    logic [WIDX_W-1:0] wptr;
    logic [7:0]        bytes_w [BLK_BYTES];

    always_ff @(posedge clk) begin
        if (rst || ptr_rst) begin
            wptr <= '0;
        end else if (host_we || host_rd) begin
            wptr <= wptr + 1'b1;
        end
    end

    for (genvar g = 0; g < BLK_BYTES; g++) begin : g_byte
        logic [7:0] b_q;
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                b_q <= '0;
            end else if (host_we && wptr == WIDX_W'(g / LANES)) begin
                b_q <= host_wdata[8*(g % LANES) +: 8];
            end else if (sh_we && sh_widx == BIDX_W'(g)) begin
                b_q <= sh_wbyte;
            end
        end
        assign bytes_w[g] = b_q;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign host_rdata[8*l +: 8] = bytes_w[{wptr, LANE_W'(l)}];
    end

    assign sh_rbyte = bytes_w[sh_ridx];

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clear |=> (host_rdata == '0)); // R5

endmodule

// File: rtl/spi_bm_top.sv
module spi_bm_top
    import spi_bm_pkg::*;
#(
    parameter int BLK_BYTES = BLK_BYTES_DEF,
    parameter int DATA_W    = DATA_W_DEF,
    parameter int LEN_W     = LEN_W_DEF,
    localparam int BIDX_W   = $clog2(BLK_BYTES),
    localparam int NB_W     = BIDX_W + 1,
    localparam int CNT_W    = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    input  logic              dio_i,
    output logic              cs_n_o
);

    ctrl_t             ctrl_q;
    logic [LEN_W-1:0]  wlen_q;
    logic [LEN_W-1:0]  rlen_q;
    xfer_state_t       state;
    logic [CNT_W-1:0]  rem;
    logic              dir_q;
    logic              tx_req;
    logic              rx_req;
    logic              busy;

    logic              cmd_wr;
    logic              start_ok;
    logic              tx_done_s;
    logic              rx_done_s;
    logic              go;
    logic [NB_W-1:0]   blk_n;
    logic              last_blk;

    logic              tick;
    logic              sh_active;
    logic              sh_sclk;
    logic              sh_sout;
    logic              sh_rx_we;
    logic [BIDX_W-1:0] sh_rx_idx;
    logic [7:0]        sh_rx_byte;
    logic              sh_done;
    logic [BIDX_W-1:0] sh_fetch;
    logic [7:0]        buf_byte;
    logic [DATA_W-1:0] buf_rdata;

    assign cmd_wr    = bus_wr && (bus_addr == A_CMD);
    assign busy      = (state != ST_IDLE);
    assign start_ok  = cmd_wr && bus_wdata[0] && ctrl_q.en && !busy;
    assign tx_done_s = cmd_wr && bus_wdata[1];
    assign rx_done_s = cmd_wr && bus_wdata[2];

    assign blk_n    = (rem >= CNT_W'(BLK_BYTES)) ? NB_W'(BLK_BYTES) : rem[NB_W-1:0];
    assign last_blk = (rem == CNT_W'(blk_n));
    assign go       = ((state == ST_WAIT_TX) && tx_done_s)
                   || (state == ST_ARM)
                   || ((state == ST_WAIT_RX) && rx_done_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            wlen_q <= '0;
            rlen_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_CTRL:  ctrl_q <= unpack_ctrl(bus_wdata);
                A_WLEN:  wlen_q <= bus_wdata[LEN_W-1:0];
                A_RLEN:  rlen_q <= bus_wdata[LEN_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            rem   <= '0;
            dir_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_ok) begin
                        dir_q <= ctrl_q.dir_rd;
                        rem   <= ctrl_q.dir_rd ? {1'b0, rlen_q} + 1'b1
                                               : {1'b0, wlen_q} + 1'b1;
                        state <= ctrl_q.dir_rd ? ST_ARM : ST_WAIT_TX;
                    end
                end
                ST_WAIT_TX: if (tx_done_s) state <= ST_SHIFT;
                ST_ARM:     state <= ST_SHIFT;
                ST_WAIT_RX: if (rx_done_s) state <= ST_SHIFT;
                ST_SHIFT: begin
                    if (sh_done) begin
                        rem <= rem - CNT_W'(blk_n);
                        if (last_blk)   state <= ST_IDLE;
                        else if (dir_q) state <= ST_WAIT_RX;
                        else            state <= ST_WAIT_TX;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_req <= 1'b0;
            rx_req <= 1'b0;
        end else begin
            if (start_ok || tx_done_s)   tx_req <= 1'b0;
            else if (sh_done && !dir_q)  tx_req <= 1'b1;
            if (start_ok || rx_done_s)   rx_req <= 1'b0;
            else if (sh_done && dir_q)   rx_req <= 1'b1;
        end
    end

    spi_bm_clkgen u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .run      (sh_active),
        .div_code (ctrl_q.div),
        .tick     (tick)
    );

    spi_bm_shifter #(.BLK_BYTES(BLK_BYTES)) u_shifter (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .nbytes    (blk_n),
        .cpol      (ctrl_q.cpol),
        .cpha      (ctrl_q.cpha),
        .tick      (tick),
        .sin       (ctrl_q.three_w ? dio_i : miso_i),
        .tx_byte   (dir_q ? 8'd0 : buf_byte),
        .fetch_idx (sh_fetch),
        .active    (sh_active),
        .sclk      (sh_sclk),
        .sout      (sh_sout),
        .rx_we     (sh_rx_we),
        .rx_idx    (sh_rx_idx),
        .rx_byte   (sh_rx_byte),
        .done      (sh_done)
    );

    spi_bm_blkbuf #(.BLK_BYTES(BLK_BYTES), .DATA_W(DATA_W)) u_blkbuf (
        .clk        (clk),
        .rst        (rst),
        .clear      (start_ok || ((state == ST_WAIT_RX) && rx_done_s)),
        .ptr_rst    (start_ok || tx_done_s || rx_done_s),
        .host_we    (bus_wr && (bus_addr == A_TXD)),
        .host_wdata (bus_wdata),
        .host_rd    (bus_rd && (bus_addr == A_RXD)),
        .host_rdata (buf_rdata),
        .sh_ridx    (sh_fetch),
        .sh_rbyte   (buf_byte),
        .sh_we      (sh_rx_we && dir_q),
        .sh_widx    (sh_rx_idx),
        .sh_wbyte   (sh_rx_byte)
    );

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = pack_ctrl(ctrl_q);
            A_WLEN:  bus_rdata = DATA_W'(wlen_q);
            A_RLEN:  bus_rdata = DATA_W'(rlen_q);
            A_STAT:  bus_rdata = DATA_W'({rx_req, tx_req, busy});
            A_RXD:   bus_rdata = buf_rdata;
            default: bus_rdata = '0;
        endcase
    end

    assign sclk_o  = sh_sclk;
    assign mosi_o  = sh_sout;
    assign mosi_oe = ctrl_q.en && !(ctrl_q.three_w && ctrl_q.dir_rd);
    assign cs_n_o  = ~ctrl_q.cs_on;

    AST_STALL_IDLE_CLK: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_WAIT_TX) || (state == ST_WAIT_RX)) |-> (sclk_o == ctrl_q.cpol)); // R6

    AST_SHIFT_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_SHIFT) && $past(state == ST_SHIFT)) |-> sh_active); // R4

    AST_DONE_IN_SHIFT: assert property (@(posedge clk) disable iff (rst)
        sh_done |-> (state == ST_SHIFT)); // R12

    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(tx_req && rx_req)); // R7

endmodule

// File: tb/spi_bm_top_tb.sv
`timescale 1ns/1ps
module spi_bm_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sclk_o, mosi_o, mosi_oe, miso_i, dio_i, cs_n_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 0;
    bit  tb_cpol = 0, tb_cpha = 0, tb_3w = 0;
    int  edge_cnt = 0;
    int  seed = 0;
    logic cap [0:2047];

    always #2.5 clk = ~clk;

    spi_bm_top u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk_o(sclk_o), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .dio_i(dio_i), .cs_n_o(cs_n_o)
    );

    function automatic logic [7:0] wr_byte(input int j, input int s);
        return 8'((j * 29 + s * 3 + 1) & 255);
    endfunction

    function automatic logic [7:0] rd_byte(input int j, input int s);
        return 8'((j * 37 + s * 11 + 5) & 255);
    endfunction

    function automatic logic pat_bit(input int n, input int s);
        logic [7:0] b;
        b = rd_byte(n / 8, s);
        return b[7 - (n % 8)];
    endfunction

    // Peripheral model: records data-out and advances the return stream on sampling edges
    always @(sclk_o) begin
        if (cs_n_o === 1'b0 && ((sclk_o ^ tb_cpol ^ tb_cpha) == 1'b1)) begin
            cap[edge_cnt] = mosi_o;
            edge_cnt = edge_cnt + 1;
        end
    end

    assign dio_i  = pat_bit(edge_cnt, seed);
    assign miso_i = tb_3w ? ~pat_bit(edge_cnt, seed) : pat_bit(edge_cnt, seed);

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [31:0] ctrl_word(input bit en, input bit cpol, input bit cpha,
                                              input bit w3, input bit cs, input bit dir,
                                              input int code);
        return {15'd0, dir, 4'd0, 4'(code), 3'd0, cs, w3, cpha, cpol, en};
    endfunction

    task automatic setup(input bit en, input bit cpol, input bit cpha, input bit w3,
                         input bit dir, input int code);
        tb_cpol = cpol; tb_cpha = cpha; tb_3w = w3;
        wr(3'd0, ctrl_word(en, cpol, cpha, w3, 1'b0, dir, code));
        repeat (3) @(negedge clk);
        wr(3'd0, ctrl_word(en, cpol, cpha, w3, 1'b1, dir, code));
        repeat (2) @(negedge clk);
        edge_cnt = 0;
    endtask

    task automatic wait_flag(input int b, output bit ok);
        logic [31:0] s;
        ok = 0;
        for (int i = 0; i < 5000; i++) begin
            rd(3'd4, s);
            if (s[b]) begin ok = 1; break; end
        end
    endtask

    task automatic run_write(input int len, input int code);
        logic [31:0] s, w;
        bit ok;
        int off, n, errs;
        seed = len;
        setup(1, len[0], len[1], 0, 0, code);
        check(cs_n_o == 1'b0, "R11 cs asserted", cs_n_o, 0);
        wr(3'd1, 32'(len - 1));
        wr(3'd3, 32'h1);
        rd(3'd4, s);
        check(s[2:0] == 3'b001, "R12 busy after start", s[2:0], 1);
        repeat (10) @(negedge clk);
        check(edge_cnt == 0 && sclk_o == tb_cpol, "R6 stall before first block", edge_cnt, 0);
        if (len == 20) begin
            wr(3'd1, 32'd1);
            wr(3'd3, 32'h1);
        end
        off = 0;
        while (off < len) begin
            n = (len - off > 16) ? 16 : len - off;
            for (int k = 0; k < (n + 3) / 4; k++) begin
                w = '0;
                for (int l = 0; l < 4; l++)
                    if (4 * k + l < n) w[8*l +: 8] = wr_byte(off + 4 * k + l, seed);
                wr(3'd5, w);
            end
            wr(3'd3, 32'h2);
            wait_flag(1, ok);
            check(ok, "R6 send-more flag rises", ok, 1);
            off += n;
            repeat (6) @(negedge clk);
            check(edge_cnt == 8 * off, "R4 bits after block", edge_cnt, 8 * off);
            rd(3'd4, s);
            check(s[0] == (off < len), "R12 busy vs remaining", s[0], off < len);
        end
        check(edge_cnt == 8 * len, "R3 total bits", edge_cnt, 8 * len);
        errs = 0;
        for (int i = 0; i < 8 * len; i++) begin
            logic [7:0] b;
            b = wr_byte(i / 8, seed);
            if (cap[i] !== b[7 - (i % 8)]) errs++;
        end
        check(errs == 0, "R9 write data msb first", errs, 0);
        check(sclk_o == tb_cpol, "R9 idle level after", sclk_o, tb_cpol);
        wr(3'd3, 32'h2);
        wr(3'd0, ctrl_word(1, tb_cpol, tb_cpha, 0, 0, 0, code));
    endtask

    task automatic run_read(input int len, input int code, input bit w3);
        logic [31:0] s, w;
        bit ok;
        int off, n, errs, ones, got;
        seed = len + 100;
        setup(1, len[1], len[0], w3, 1, code);
        check(mosi_oe == !w3, "R10 output enable", mosi_oe, !w3);
        wr(3'd2, 32'(len - 1));
        wr(3'd3, 32'h1);
        off = 0; errs = 0;
        while (off < len) begin
            n = (len - off > 16) ? 16 : len - off;
            wait_flag(2, ok);
            check(ok, "R7 data-waiting flag rises", ok, 1);
            repeat (10) @(negedge clk);
            check(edge_cnt == 8 * (off + n) && sclk_o == tb_cpol,
                  "R7 stall while block pending", edge_cnt, 8 * (off + n));
            if (w3) check(mosi_oe == 1'b0, "R10 pin released", mosi_oe, 0);
            for (int k = 0; k < (n + 3) / 4; k++) begin
                rd(3'd6, w);
                for (int l = 0; l < 4; l++) begin
                    logic [7:0] e;
                    e = (4 * k + l < n) ? rd_byte(off + 4 * k + l, seed) : 8'd0;
                    if (w[8*l +: 8] !== e) errs++;
                end
            end
            wr(3'd3, 32'h4);
            off += n;
        end
        repeat (4) @(negedge clk);
        rd(3'd4, s);
        check(s[2:0] == 3'b000, "R12 idle after read", s[2:0], 0);
        check(errs == 0, w3 ? "R10 three-wire read data" : "R5 read lanes", errs, 0);
        ones = 0;
        for (int i = 0; i < 8 * len; i++) if (cap[i] !== 1'b0) ones++;
        check(ones == 0, "R2 data-out low on read", ones, 0);
        got = edge_cnt;
        check(got == 8 * len, "R3 read bit count", got, 8 * len);
        wr(3'd0, ctrl_word(1, tb_cpol, tb_cpha, w3, 0, 1, code));
    endtask

    task automatic run_div(input int code);
        realtime t1, t2;
        bit ok;
        int h;
        h = (code == 0) ? 1 : code;
        seed = code;
        setup(1, 0, 0, 0, 0, code);
        wr(3'd1, 32'd0);
        wr(3'd3, 32'h1);
        wr(3'd5, 32'h0000_00A5);
        wr(3'd3, 32'h2);
        @(posedge sclk_o); t1 = $realtime;
        @(posedge sclk_o); t2 = $realtime;
        check(int'(t2 - t1) == 10 * h, "R1 sclk period", int'(t2 - t1), 10 * h);
        wait_flag(1, ok);
        wr(3'd3, 32'h2);
        wr(3'd0, ctrl_word(1, 0, 0, 0, 0, 0, code));
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] s;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(3'd4, s);
        check(s == 32'd0, "R13 status after reset", s, 0);
        check(cs_n_o == 1'b1 && sclk_o == 1'b0 && mosi_o == 1'b0,
              "R13 pins after reset", {cs_n_o, sclk_o, mosi_o}, 3'b100);

        // R8: start ignored while disabled
        setup(0, 0, 0, 0, 0, 1);
        wr(3'd1, 32'd3);
        wr(3'd3, 32'h1);
        wr(3'd3, 32'h2);
        repeat (40) @(negedge clk);
        rd(3'd4, s);
        check(s[0] == 1'b0 && edge_cnt == 0, "R8 start ignored when disabled", edge_cnt, 0);
        wr(3'd0, 32'd0);
        check(cs_n_o == 1'b1, "R11 cs released", cs_n_o, 1);

        for (int len = 1; len <= 20; len++) run_write(len, len % 3);
        for (int len = 1; len <= 20; len++) run_read(len, (len + 1) % 3, 1'b0);
        run_read(7, 2, 1'b1);
        for (int c = 0; c < 16; c++) run_div(c);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule